// File: doc/BRIEF.md
# Double-Buffered PWM Reload Controller

This block is one pulse-width generator channel with two outputs. A free-running up-counter, slowed by a power-of-two prescaler, sweeps from zero to the active modulus minus one. Each output is high while the count is below its own active pulse width. Software sets a new prescaler, modulus and pair of pulse widths by writing shadow registers. It then arms a load-okay flag. The shadow values are copied into the active set at the next reload boundary only, so a PWM period never runs with a mix of old and new settings.

The load-okay flag can only be armed through a handshake: a read of the control register that sees the flag clear, then a write of one. The flag clears itself when the copy is made. A select bit can hand the load decision to an external global load-okay line instead. A restart option lets a commutation pulse begin a fresh period at once. A write-protect latch freezes both of these options. A mode bit gates software access to the enable, load-okay and interrupt-enable bits.

Register map (16-bit data, 3-bit address):

- Control, address 0:
  - bit 0: enable
  - bit 1: load-okay
  - bit 2: reload interrupt enable
  - bit 3: global-load select
  - bit 4: restart-on-commutation
  - bit 5: write protect, settable only
  - bit 6: mode
  - bits 9:8: output overrides for B and A
- Frequency, address 1:
  - low bits: prescaler exponent
  - bit 15: reload flag, write one to clear
- Modulus, address 2.
- Pulse width A, address 3.
- Pulse width B, address 4.

Top module: `pwmr_top`

## Requirements
- R1: After reset, the control, frequency, modulus and pulse-width registers read zero, both outputs are low and the interrupt line is low.
- R2: While the mode bit (control bit 6) is clear, the enable, load-okay and interrupt-enable bits (control bits 0, 1, 2) read zero and writes to them have no effect.
- R3: The load-okay bit (control bit 1) becomes set only on a control write with bit 1 high that follows a control read made while the flag read zero. A write of one without such a read leaves it clear.
- R4: Writing zero to control bit 1 clears the load-okay flag. The flag also clears by itself at the reload where the shadow values are transferred.
- R5: The shadow values take effect at the next reload after arming. With modulus M, prescaler exponent P and pulse widths WA and WB:
  - the period is M·2^P clock cycles;
  - output A is high for min(WA,M)·2^P cycles of each period;
  - output B is high for min(WB,M)·2^P cycles of each period.
- R6: With global-load select (control bit 3) set, the external global load-okay input decides the transfer and the local flag is ignored.
- R7: With restart (control bit 4) set, a commutation pulse while running restarts the counter at zero and is a reload boundary. With the bit clear, the pulse is ignored.
- R8: Once write protect (control bit 5) is set, control bits 3, 4 and 5 keep their values until reset.
- R9: Setting the enable bit starts the counter with a reload in the following cycle. While the generator is disabled, output A follows override bit 8, output B follows override bit 9, and no reload occurs.
- R10: The reload flag (frequency bit 15) sets at every reload boundary. Writing one to it clears it. If a clear and a set arrive in the same cycle, the set wins.
- R11: The interrupt line is high exactly when the reload flag and the reload interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used by the load-okay handshake) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| glob_ld_ok | input | 1 | External global load-okay |
| commut_evt | input | 1 | Commutation event pulse |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| reload_irq | output | 1 | Reload interrupt request |

## Verification
The hardest case to reach from the ports is a software clear of the reload flag that lands in the same cycle as a reload. The bench forces this by loading a modulus of one with no prescaling. A reload then happens on every clock, so any clear write must collide with a set. A commutation restart in the middle of a period is the other delicate case. The bench aligns to a reload by polling the flag, counts a known number of cycles, and only then pulses the commutation input, so the expected count and output are known exactly.

// File: rtl/pwmr_pkg.sv
package pwmr_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_FREQ = 3'd1;
    localparam logic [ADDR_W-1:0] A_MOD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PWA  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PWB  = 3'd4;

    localparam int B_EN    = 0;
    localparam int B_LDOK  = 1;
    localparam int B_RIE   = 2;
    localparam int B_GSEL  = 3;
    localparam int B_RSEL  = 4;
    localparam int B_WP    = 5;
    localparam int B_MGM   = 6;
    localparam int B_OVRA  = 8;
    localparam int B_OVRB  = 9;
    localparam int B_RFLAG = 15;
endpackage

// File: rtl/pwmr_regs.sv
module pwmr_regs
    import pwmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               glob_ld_ok,
    input  logic               reload_evt,
    input  logic               load_done,
    output logic               en_eff,
    output logic               load_ok,
    output logic               ldok_q,
    output logic               gsel,
    output logic               rsel,
    output logic               wp,
    output logic               rflag,
    output logic [1:0]         ovr,
    output logic [PSC_W-1:0]   sh_psc,
    output logic [CNT_W-1:0]   sh_mod,
    output logic [CNT_W-1:0]   sh_pwa,
    output logic [CNT_W-1:0]   sh_pwb,
    output logic               irq
);
    typedef struct packed {
        logic             en;
        logic             ldok;
        logic             rie;
        logic             gsel;
        logic             rsel;
        logic             wp;
        logic             mgm;
        logic [1:0]       ovr;
        logic             arm;
        logic             rflag;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] mod;
        logic [CNT_W-1:0] pwa;
        logic [CNT_W-1:0] pwb;
    } reg_st_t;

    reg_st_t q, d;
    logic    ctrl_wr;

    always_comb begin
        d       = q;
        ctrl_wr = bus_wr && (bus_addr == A_CTRL);
        // handshake: a read that sees the flag low primes the next write
        if (bus_rd && bus_addr == A_CTRL && q.mgm && !q.ldok)
            d.arm = 1'b1;
        if (ctrl_wr) begin
            d.arm = 1'b0;
            d.mgm = bus_wdata[B_MGM];
            d.ovr = bus_wdata[B_OVRB:B_OVRA];
            d.wp  = q.wp | bus_wdata[B_WP];
            if (!q.wp) begin
                d.gsel = bus_wdata[B_GSEL];
                d.rsel = bus_wdata[B_RSEL];
            end
            if (q.mgm) begin
                d.en  = bus_wdata[B_EN];
                d.rie = bus_wdata[B_RIE];
                if (!bus_wdata[B_LDOK])
                    d.ldok = 1'b0;
                else if (q.arm)
                    d.ldok = 1'b1;
            end
        end
        if (load_done && !q.gsel)
            d.ldok = 1'b0;
        if (bus_wr && bus_addr == A_FREQ) begin
            d.psc = bus_wdata[PSC_W-1:0];
            if (bus_wdata[B_RFLAG])
                d.rflag = 1'b0;
        end
        if (bus_wr && bus_addr == A_MOD) d.mod = bus_wdata[CNT_W-1:0];
        if (bus_wr && bus_addr == A_PWA) d.pwa = bus_wdata[CNT_W-1:0];
        if (bus_wr && bus_addr == A_PWB) d.pwb = bus_wdata[CNT_W-1:0];
        if (reload_evt)
            d.rflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]   = q.en & q.mgm;
                bus_rdata[B_LDOK] = q.ldok & q.mgm;
                bus_rdata[B_RIE]  = q.rie & q.mgm;
                bus_rdata[B_GSEL] = q.gsel;
                bus_rdata[B_RSEL] = q.rsel;
                bus_rdata[B_WP]   = q.wp;
                bus_rdata[B_MGM]  = q.mgm;
                bus_rdata[B_OVRB:B_OVRA] = q.ovr;
            end
            A_FREQ: begin
                bus_rdata[PSC_W-1:0] = q.psc;
                bus_rdata[B_RFLAG]   = q.rflag;
            end
            A_MOD:   bus_rdata[CNT_W-1:0] = q.mod;
            A_PWA:   bus_rdata[CNT_W-1:0] = q.pwa;
            A_PWB:   bus_rdata[CNT_W-1:0] = q.pwb;
            default: bus_rdata = '0;
        endcase
    end

    assign en_eff  = q.en & q.mgm;
    assign load_ok = q.gsel ? glob_ld_ok : (q.ldok & q.mgm);
    assign ldok_q  = q.ldok;
    assign gsel    = q.gsel;
    assign rsel    = q.rsel;
    assign wp      = q.wp;
    assign rflag   = q.rflag;
    assign ovr     = q.ovr;
    assign sh_psc  = q.psc;
    assign sh_mod  = q.mod;
    assign sh_pwa  = q.pwa;
    assign sh_pwb  = q.pwb;
    assign irq     = q.rflag & q.rie & q.mgm;
endmodule

// File: rtl/pwmr_core.sv
module pwmr_core #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load_ok,
    input  logic             rsel,
    input  logic             commut,
    input  logic [1:0]       ovr,
    input  logic [PSC_W-1:0] sh_psc,
    input  logic [CNT_W-1:0] sh_mod,
    input  logic [CNT_W-1:0] sh_pwa,
    input  logic [CNT_W-1:0] sh_pwb,
    output logic             reload_evt,
    output logic             load_done,
    output logic             out_a,
    output logic             out_b
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] pcnt;
        logic [PSC_W-1:0] apsc;
        logic [CNT_W-1:0] amod;
        logic [CNT_W-1:0] apwa;
        logic [CNT_W-1:0] apwb;
    } core_st_t;

    core_st_t         q, d;
    logic [DIV_W-1:0] lim;
    logic [CNT_W:0]   cnt_nx;
    logic             tick, wrap, restart_hit;

    always_comb begin
        d           = q;
        reload_evt  = 1'b0;
        load_done   = 1'b0;
        lim         = ~({DIV_W{1'b1}} << q.apsc);
        tick        = (q.pcnt == lim);
        cnt_nx      = {1'b0, q.cnt} + (CNT_W+1)'(1);
        wrap        = tick && (cnt_nx >= {1'b0, q.amod});
        restart_hit = rsel && commut && q.run;
        if (!en) begin
            d.run  = 1'b0;
            d.cnt  = '0;
            d.pcnt = '0;
        end else if (!q.run || wrap || restart_hit) begin
            reload_evt = 1'b1;
            d.run      = 1'b1;
            d.cnt      = '0;
            d.pcnt     = '0;
            if (load_ok) begin
                load_done = 1'b1;
                d.apsc    = sh_psc;
                d.amod    = sh_mod;
                d.apwa    = sh_pwa;
                d.apwb    = sh_pwb;
            end
        end else if (tick) begin
            d.pcnt = '0;
            d.cnt  = cnt_nx[CNT_W-1:0];
        end else begin
            d.pcnt = q.pcnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_a = q.run ? (q.cnt < q.apwa) : ovr[0];
    assign out_b = q.run ? (q.cnt < q.apwb) : ovr[1];
endmodule

// File: rtl/pwmr_top.sv
module pwmr_top
    import pwmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              glob_ld_ok,
    input  logic              commut_evt,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              reload_irq
);
    logic             reload_evt, load_done, en_eff, load_ok;
    logic             ldok_q, gsel, rsel, wp, rflag;
    logic [1:0]       ovr;
    logic [PSC_W-1:0] sh_psc;
    logic [CNT_W-1:0] sh_mod, sh_pwa, sh_pwb;

    pwmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glob_ld_ok(glob_ld_ok), .reload_evt(reload_evt), .load_done(load_done),
        .en_eff(en_eff), .load_ok(load_ok), .ldok_q(ldok_q),
        .gsel(gsel), .rsel(rsel), .wp(wp), .rflag(rflag), .ovr(ovr),
        .sh_psc(sh_psc), .sh_mod(sh_mod), .sh_pwa(sh_pwa), .sh_pwb(sh_pwb),
        .irq(reload_irq)
    );

    pwmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .en(en_eff), .load_ok(load_ok), .rsel(rsel), .commut(commut_evt),
        .ovr(ovr), .sh_psc(sh_psc), .sh_mod(sh_mod), .sh_pwa(sh_pwa),
        .sh_pwb(sh_pwb), .reload_evt(reload_evt), .load_done(load_done),
        .out_a(pwm_a), .out_b(pwm_b)
    );
endmodule

// File: rtl/pwmr_chk.sv
module pwmr_chk
    import pwmr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic        reload_evt,
    input logic        load_done,
    input logic        en_eff,
    input logic [1:0]  ovr,
    input logic        pwm_a,
    input logic        pwm_b,
    input logic        reload_irq,
    input logic        ldok_q,
    input logic        gsel,
    input logic        rsel,
    input logic        wp,
    input logic        rflag
);
    AST_LOAD_ONLY_AT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> reload_evt); // R5

    AST_LDOK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && !gsel) |=> !ldok_q); // R4

    AST_LDOK_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldok_q) |-> $past(bus_wr && bus_addr == A_CTRL)); // R3

    AST_PROTECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wp) |-> ($stable(gsel) && $stable(rsel) && wp)); // R8

    AST_IDLE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_eff) |-> (pwm_a == ovr[0] && pwm_b == ovr[1])); // R9

    AST_FLAG_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_evt |=> rflag); // R10

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_irq && !$past(reload_irq)) |->
            ($past(reload_evt) || $past(bus_wr && bus_addr == A_CTRL))); // R11
endmodule

bind pwmr_top pwmr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .reload_evt(reload_evt), .load_done(load_done), .en_eff(en_eff),
    .ovr(ovr), .pwm_a(pwm_a), .pwm_b(pwm_b), .reload_irq(reload_irq),
    .ldok_q(ldok_q), .gsel(gsel), .rsel(rsel), .wp(wp), .rflag(rflag)
);

// File: tb/pwmr_top_tb.sv
`timescale 1ns/1ps
module pwmr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        glob_ld_ok = 1'b0, commut_evt = 1'b0;
    logic        pwm_a, pwm_b, reload_irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glob_ld_ok(glob_ld_ok), .commut_evt(commut_evt),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .reload_irq(reload_irq)
    );

    // mod, width A, width B, prescaler exp, expected high A, high B, period
    localparam int NV = 6;
    localparam int VEC [NV][7] = '{
        '{10, 3,  7, 0,  3,  7, 10},
        '{ 6, 6,  0, 1, 12,  0, 12},
        '{ 5, 9,  2, 2, 20,  8, 20},
        '{12, 1, 11, 3,  8, 88, 96},
        '{ 1, 1,  0, 0,  1,  0,  1},
        '{16, 8,  8, 0,  8,  8, 16}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int dat);
        bus_addr = a; bus_wdata = 16'(dat); bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; #1;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; #1;
    endtask

    task automatic peek(input logic [2:0] a, output int val);
        bus_addr = a; #0.5; val = int'(bus_rdata);
    endtask

    // clear the reload flag, then wait for the next reload
    task automatic sync(input int psc);
        int guard = 0;
        wr(3'd1, 16'h8000 | psc);
        bus_addr = 3'd1; #0.5;
        while (!bus_rdata[15] && guard < 4000) begin
            @(negedge clk); #1; guard++;
        end
    endtask

    // called just after a reload: count output highs until the next reload
    task automatic measure(input int psc, output int ha, output int hb, output int per);
        ha = 0; hb = 0; per = 0;
        bus_addr = 3'd1; bus_wdata = 16'(16'h8000 | psc); bus_wr = 1'b1;
        do begin
            ha += int'(pwm_a); hb += int'(pwm_b); per++;
            @(negedge clk); #1; bus_wr = 1'b0;
        end while (!bus_rdata[15] && per < 4000);
    endtask

    initial begin
        int v, ha, hb, per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        peek(3'd0, v); check("R1 ctrl", v, 0);
        peek(3'd1, v); check("R1 freq", v, 0);
        peek(3'd2, v); check("R1 mod", v, 0);
        peek(3'd3, v); check("R1 width A", v, 0);
        check("R1 outputs", {pwm_b, pwm_a}, 0);
        check("R1 irq", reload_irq, 0);

        // R2 mode gating
        wr(3'd0, 16'h0007);
        peek(3'd0, v); check("R2 gated bits", v, 0);
        @(negedge clk); #1;
        check("R2 generator idle", {pwm_b, pwm_a}, 0);

        // R3 handshake, R4 manual clear
        wr(3'd0, 16'h0040);
        wr(3'd0, 16'h0042);
        peek(3'd0, v); check("R3 no read first", v, 16'h0040);
        rd(3'd0);
        wr(3'd0, 16'h0042);
        peek(3'd0, v); check("R3 read then write", v, 16'h0042);
        wr(3'd0, 16'h0040);
        peek(3'd0, v); check("R4 manual clear", v, 16'h0040);

        // R5 table of settings, each armed then measured over one period
        for (int i = 0; i < NV; i++) begin
            wr(3'd2, VEC[i][0]);
            wr(3'd3, VEC[i][1]);
            wr(3'd4, VEC[i][2]);
            wr(3'd1, 16'h8000 | VEC[i][3]);
            rd(3'd0);
            wr(3'd0, 16'h0043);
            sync(VEC[i][3]);
            measure(VEC[i][3], ha, hb, per);
            check($sformatf("R5 vec%0d high A", i), ha, VEC[i][4]);
            check($sformatf("R5 vec%0d high B", i), hb, VEC[i][5]);
            check($sformatf("R5 vec%0d period", i), per, VEC[i][6]);
            peek(3'd0, v); check("R4 self clear", (v >> 1) & 1, 0);
        end

        // R6 global load select
        wr(3'd0, 16'h0049);
        wr(3'd3, 2);
        rd(3'd0);
        wr(3'd0, 16'h004B);
        sync(0); measure(0, ha, hb, per);
        check("R6 local flag ignored", ha, 8);
        glob_ld_ok = 1'b1;
        sync(0); measure(0, ha, hb, per);
        check("R6 global load taken", ha, 2);
        glob_ld_ok = 1'b0;
        wr(3'd0, 16'h0041);

        // R7 restart on commutation
        wr(3'd0, 16'h0051);
        sync(0);
        repeat (5) @(negedge clk);
        #1; wr(3'd1, 16'h8000);
        peek(3'd1, v); check("R10 flag cleared", v, 0);
        commut_evt = 1'b1; @(negedge clk); commut_evt = 1'b0; #1;
        peek(3'd1, v); check("R7 restart flag", v, 16'h8000);
        check("R7 count back at zero", pwm_a, 1);
        wr(3'd0, 16'h0041);
        sync(0);
        repeat (3) @(negedge clk);
        #1; wr(3'd1, 16'h8000);
        commut_evt = 1'b1; @(negedge clk); commut_evt = 1'b0; #1;
        peek(3'd1, v); check("R7 commut ignored flag", v, 0);
        check("R7 commut ignored output", pwm_a, 0);

        // R8 write protect
        wr(3'd0, 16'h0071);
        peek(3'd0, v); check("R8 protect set", v, 16'h0071);
        wr(3'd0, 16'h0049);
        peek(3'd0, v); check("R8 frozen bits", v, 16'h0071);

        // R11 interrupt
        sync(0);
        check("R11 no enable", reload_irq, 0);
        wr(3'd0, 16'h0075);
        check("R11 flag and enable", reload_irq, 1);

        // R10 set beats clear: modulus 1 gives a reload every cycle
        wr(3'd2, 1);
        rd(3'd0);
        wr(3'd0, 16'h0077);
        sync(0);
        @(negedge clk); #1;
        wr(3'd1, 16'h8000);
        peek(3'd1, v); check("R10 set wins", v, 16'h8000);

        // R9 disabled outputs follow overrides, enable starts with a reload
        wr(3'd0, 16'h0240);
        @(negedge clk); #1;
        check("R9 override A", pwm_a, 0);
        check("R9 override B", pwm_b, 1);
        wr(3'd1, 16'h8000);
        @(negedge clk); #1;
        peek(3'd1, v); check("R9 no reload while off", v, 0);
        wr(3'd0, 16'h0241);
        @(negedge clk); #1;
        peek(3'd1, v); check("R9 enable reload", v, 16'h8000);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule